// File: doc/BRIEF.md
# Serial Bus Frame Receiver and Message Classifier

This block takes a serial bit stream whose clock has already been recovered. A one-cycle strobe marks each valid bit. The block finds frame boundaries marked by the flag octet, removes the zero bits the transmitter inserted for transparency, and rebuilds the message octets. It checks the 16-bit CRC that closes each frame. The octets reach the consumer as a byte stream with the two check octets already removed. When the frame closes, the block reports one result: a structural-error flag, a CRC-good flag, a decoded message kind, and the address carried in the first message octet.

The classifier knows the short command messages that the bus controller sends. These are frame start, frame control, the two handover commands, and single-octet user requests. It also picks out the multi-word status messages that carry a controller address, and sorts everything else as user data. Word-level checksums inside user data are checked further downstream.

Top module: `sbus_rx_deframer`

## Requirements
- R1: Bits are taken only in cycles where `bit_vld` is high, and octets are sent least significant bit first. While hunting, every bit is ignored until the flag pattern 0,1,1,1,1,1,1,0 (octet 0x7E) is seen. That flag opens a frame.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed and never becomes part of an octet. Octets 0x7E and 0xFF in the message therefore arrive intact.
- R3: A flag that comes after at least one complete octet closes the frame. `frame_end` then pulses for exactly one cycle, and the same flag also opens the next frame. A flag with no complete octet since the previous flag gives no `frame_end`.
- R4: Every message octet is delivered on `byte_data` with a one-cycle `byte_vld`, in arrival order. The last two octets before the closing flag are the check field and are never delivered.
- R5: The check is the reflected CCITT CRC (polynomial 0x8408, seed 0xFFFF). The transmitter sends its complement, low octet first. `frame_crc_ok` is 1 for a well-formed frame whose check matches, and 0 when it does not match.
- R6: A frame with one message octet is classified into `msg_kind` as follows: 0x80 gives 1 (frame start), 0x81 gives 2 (frame control), 0x8A gives 3 (handover to pilot), 0x8E gives 4 (handover to copilot), and any other value gives 5 (user request).
- R7: A frame with two or more message octets whose first octet is 0xA4 to 0xA7 gives `msg_kind` 6 (controller status), with `ctrl_id` = 0 to 3 for controllers 1 to 4. Any other first octet gives 7 (user data) with `ctrl_id` 0.
- R8: A frame is malformed if its bit count between flags is not a whole number of octets, or if it holds fewer than three octets. A malformed frame reports `frame_err`=1, `frame_crc_ok`=0 and `msg_kind` 0.
- R9: A run of seven 1s inside a frame aborts it. If any octet had been completed, `frame_end` pulses with `frame_err`=1. The receiver then goes back to hunting and needs a new opening flag.
- R10: `msg_addr` is the first message octet. All report outputs change only in the cycle of `frame_end` and hold their values until the next one.
- R11: After a synchronous reset, `byte_vld` and `frame_end` are 0 and all report outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe marking a valid received bit |
| bit_in | input | 1 | Received bit value |
| byte_vld | output | 1 | One-cycle strobe for a delivered message octet |
| byte_data | output | 8 | Delivered message octet |
| frame_end | output | 1 | One-cycle strobe when a frame closes or aborts |
| frame_err | output | 1 | Frame was malformed or aborted |
| frame_crc_ok | output | 1 | Check field matched on a well-formed frame |
| msg_kind | output | 3 | Decoded message kind (codes in R6, R7) |
| msg_addr | output | 8 | First message octet |
| ctrl_id | output | 2 | Controller index for status messages |

## Verification
The assertions assume that two flags are always at least eight strobes apart, which any legal bit stream guarantees. They also assume that `bit_in` is only meaningful while `bit_vld` is high. The bench builds every frame the way a transmitter would: opening flag, zero insertion after five 1s, complemented check field, closing flag and a trailing mark. It presents one bit every third clock, so strobes never arrive back to back. Only the abort, misalignment, short-frame and garbage-before-flag cases step outside a legal stream. Each of those is built on purpose, with the expected report worked out from R8 and R9.

// File: rtl/sbus_rx_pkg.sv
package sbus_rx_pkg;

    localparam int OCT_W     = 8;
    localparam int BIT_IDX_W = $clog2(OCT_W);
    localparam int CRC_W     = 16;

    localparam logic [OCT_W-1:0] OCT_FRAME_START = 8'h80;
    localparam logic [OCT_W-1:0] OCT_FRAME_CTRL  = 8'h81;
    localparam logic [OCT_W-1:0] OCT_HAND_PILOT  = 8'h8A;
    localparam logic [OCT_W-1:0] OCT_HAND_COPLT  = 8'h8E;
    localparam logic [OCT_W-1:0] OCT_CSTAT_LO    = 8'hA4;
    localparam logic [OCT_W-1:0] OCT_CSTAT_HI    = 8'hA7;

    localparam logic [CRC_W-1:0] CRC_SEED    = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_R  = 16'h8408;
    localparam logic [CRC_W-1:0] CRC_RESIDUE = 16'hF0B8;

    typedef enum logic [2:0] {
        KIND_NONE      = 3'd0,
        KIND_FSTART    = 3'd1,
        KIND_FCTRL     = 3'd2,
        KIND_HAND_PLT  = 3'd3,
        KIND_HAND_CPLT = 3'd4,
        KIND_USER_REQ  = 3'd5,
        KIND_CSTAT     = 3'd6,
        KIND_USER_DATA = 3'd7
    } msg_kind_e;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } rx_state_e;

    // Per-strobe event produced by the line stage.
    typedef struct packed {
        logic data_vld;
        logic data_bit;
        logic flag;
        logic abort;
    } line_ev_t;

    // Summary of a frame at the moment it closes.
    typedef struct packed {
        logic             done;
        logic             aborted;
        logic             aligned;
        logic             crc_match;
        logic             short_frame;
        logic             single_oct;
        logic [OCT_W-1:0] first_oct;
    } frame_sum_t;

    // Report that the top holds between frame ends.
    typedef struct packed {
        msg_kind_e        kind;
        logic [OCT_W-1:0] addr;
        logic [1:0]       ctrl_id;
        logic             err;
        logic             crc_ok;
    } frame_rpt_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [OCT_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < OCT_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/sbus_rx_bitline.sv
module sbus_rx_bitline
    import sbus_rx_pkg::*;
#(
    parameter int RUN_W = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_vld,
    input  logic     bit_in,
    output line_ev_t ev
);

    localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(5);
    localparam logic [RUN_W-1:0] RUN_FLAG  = RUN_W'(6);
    localparam logic [RUN_W-1:0] RUN_SAT   = RUN_W'(7);

    logic [RUN_W-1:0] ones_q;

    // Classify the current bit against the run of ones before it.
    always_comb begin
        ev = '0;
        if (bit_vld) begin
            if (bit_in) begin
                if (ones_q >= RUN_FLAG) begin
                    ev.abort = 1'b1;
                end else begin
                    ev.data_vld = 1'b1;
                    ev.data_bit = 1'b1;
                end
            end else begin
                if (ones_q == RUN_FLAG) begin
                    ev.flag = 1'b1;
                end else if (ones_q != RUN_STUFF) begin
                    ev.data_vld = 1'b1;
                    ev.data_bit = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q <= '0;
        end else if (bit_vld) begin
            if (!bit_in)               ones_q <= '0;
            else if (ones_q != RUN_SAT) ones_q <= ones_q + RUN_W'(1);
        end
    end

    // R2: an inserted zero after five ones never becomes data
    a_r2_stuffed_zero_dropped: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && !bit_in && ones_q == RUN_STUFF) |-> (!ev.data_vld && !ev.flag));

endmodule

// File: rtl/sbus_rx_framer.sv
module sbus_rx_framer
    import sbus_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev,
    output logic             oct_vld,
    output logic [OCT_W-1:0] oct_data,
    output frame_sum_t       sum
);

    localparam logic [BIT_IDX_W-1:0] LAST_BIT  = BIT_IDX_W'(OCT_W - 1);
    localparam logic [CNT_W-1:0]     CHK_OCTS  = CNT_W'(2);
    localparam logic [CNT_W-1:0]     MIN_OCTS  = CNT_W'(3);
    localparam logic [CNT_W-1:0]     CNT_SAT   = {CNT_W{1'b1}};

    rx_state_e              state_q;
    logic [OCT_W-1:0]       sr_q;
    logic [BIT_IDX_W-1:0]   nb_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [OCT_W-1:0]       hold0_q;
    logic [OCT_W-1:0]       hold1_q;
    logic [CRC_W-1:0]       crc_q;
    logic [OCT_W-1:0]       first_q;
    logic [OCT_W-1:0]       oct_new;
    logic                   in_frame;

    assign oct_new  = {ev.data_bit, sr_q[OCT_W-1:1]};
    assign in_frame = (state_q == ST_FRAME);

    // Frame close: a flag or abort after at least one complete octet.
    always_comb begin
        sum.done        = in_frame && (ev.flag || ev.abort) && (cnt_q != '0);
        sum.aborted     = ev.abort;
        sum.aligned     = (nb_q == LAST_BIT);
        sum.crc_match   = (crc_q == CRC_RESIDUE);
        sum.short_frame = (cnt_q < MIN_OCTS);
        sum.single_oct  = (cnt_q == MIN_OCTS);
        sum.first_oct   = first_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HUNT;
            sr_q     <= '0;
            nb_q     <= '0;
            cnt_q    <= '0;
            hold0_q  <= '0;
            hold1_q  <= '0;
            crc_q    <= CRC_SEED;
            first_q  <= '0;
            oct_vld  <= 1'b0;
            oct_data <= '0;
        end else begin
            oct_vld <= 1'b0;
            unique case (state_q)
                ST_HUNT: begin
                    if (ev.flag) begin
                        state_q <= ST_FRAME;
                        nb_q    <= '0;
                        cnt_q   <= '0;
                        crc_q   <= CRC_SEED;
                    end
                end
                ST_FRAME: begin
                    if (ev.abort) begin
                        state_q <= ST_HUNT;
                    end else if (ev.flag) begin
                        nb_q  <= '0;
                        cnt_q <= '0;
                        crc_q <= CRC_SEED;
                    end else if (ev.data_vld) begin
                        sr_q <= oct_new;
                        nb_q <= nb_q + BIT_IDX_W'(1);
                        if (nb_q == LAST_BIT) begin
                            crc_q   <= crc_step(crc_q, oct_new);
                            hold0_q <= oct_new;
                            hold1_q <= hold0_q;
                            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CNT_W'(1);
                            if (cnt_q == '0) first_q <= oct_new;
                            // Two octets stay held back: they may be the check field.
                            if (cnt_q >= CHK_OCTS) begin
                                oct_vld  <= 1'b1;
                                oct_data <= hold1_q;
                            end
                        end
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    // R1/R4: octets only come out of frame reception
    a_r4_octet_only_in_frame: assert property (@(posedge clk) disable iff (rst)
        oct_vld |-> ($past(state_q) == ST_FRAME));

    // R3: a flag inside a frame restarts octet assembly
    a_r3_flag_restarts: assert property (@(posedge clk) disable iff (rst)
        (in_frame && ev.flag && !ev.abort) |=> (nb_q == '0 && cnt_q == '0));

endmodule

// File: rtl/sbus_rx_classify.sv
module sbus_rx_classify
    import sbus_rx_pkg::*;
(
    input  frame_sum_t sum,
    output frame_rpt_t rpt
);

    logic err;
    logic is_cstat;

    assign err      = sum.aborted || !sum.aligned || sum.short_frame;
    assign is_cstat = (sum.first_oct >= OCT_CSTAT_LO) && (sum.first_oct <= OCT_CSTAT_HI);

    always_comb begin
        rpt.addr    = sum.first_oct;
        rpt.err     = err;
        rpt.crc_ok  = !err && sum.crc_match;
        rpt.ctrl_id = 2'b00;
        rpt.kind    = KIND_NONE;
        if (!err) begin
            if (sum.single_oct) begin
                unique case (sum.first_oct)
                    OCT_FRAME_START: rpt.kind = KIND_FSTART;
                    OCT_FRAME_CTRL:  rpt.kind = KIND_FCTRL;
                    OCT_HAND_PILOT:  rpt.kind = KIND_HAND_PLT;
                    OCT_HAND_COPLT:  rpt.kind = KIND_HAND_CPLT;
                    default:         rpt.kind = KIND_USER_REQ;
                endcase
            end else if (is_cstat) begin
                rpt.kind    = KIND_CSTAT;
                rpt.ctrl_id = sum.first_oct[1:0];
            end else begin
                rpt.kind = KIND_USER_DATA;
            end
        end
    end

endmodule

// File: rtl/sbus_rx_deframer.sv
module sbus_rx_deframer
    import sbus_rx_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int RUN_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_vld,
    input  logic       bit_in,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       frame_end,
    output logic       frame_err,
    output logic       frame_crc_ok,
    output logic [2:0] msg_kind,
    output logic [7:0] msg_addr,
    output logic [1:0] ctrl_id
);

    line_ev_t   ev;
    frame_sum_t sum;
    frame_rpt_t rpt;
    frame_rpt_t rpt_q;
    logic       end_q;

    sbus_rx_bitline #(.RUN_W(RUN_W)) u_line (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .ev      (ev)
    );

    sbus_rx_framer #(.CNT_W(CNT_W)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .oct_vld  (byte_vld),
        .oct_data (byte_data),
        .sum      (sum)
    );

    sbus_rx_classify u_class (
        .sum (sum),
        .rpt (rpt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            end_q <= 1'b0;
            rpt_q <= '0;
        end else begin
            end_q <= sum.done;
            if (sum.done) rpt_q <= rpt;
        end
    end

    assign frame_end    = end_q;
    assign frame_err    = rpt_q.err;
    assign frame_crc_ok = rpt_q.crc_ok;
    assign msg_kind     = rpt_q.kind;
    assign msg_addr     = rpt_q.addr;
    assign ctrl_id      = rpt_q.ctrl_id;

    // R3: the end strobe lasts one cycle
    a_r3_end_single_cycle: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);

    // R7: status kind only for controller addresses
    a_r7_cstat_addr_range: assert property (@(posedge clk) disable iff (rst)
        (frame_end && msg_kind == KIND_CSTAT) |-> (msg_addr >= OCT_CSTAT_LO && msg_addr <= OCT_CSTAT_HI));

    // R8: malformed frames carry no kind and no good check
    a_r8_err_clears_report: assert property (@(posedge clk) disable iff (rst)
        (frame_end && frame_err) |-> (!frame_crc_ok && msg_kind == KIND_NONE));

    // R10: report holds between frame ends
    a_r10_report_holds: assert property (@(posedge clk) disable iff (rst)
        !frame_end |-> ($stable(msg_kind) && $stable(msg_addr) && $stable(frame_err)
                        && $stable(frame_crc_ok) && $stable(ctrl_id)));

endmodule

// File: tb/sbus_rx_deframer_bench.sv
module sbus_rx_deframer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic       frame_end;
    logic       frame_err;
    logic       frame_crc_ok;
    logic [2:0] msg_kind;
    logic [7:0] msg_addr;
    logic [1:0] ctrl_id;

    int checks = 0;
    int errors = 0;
    int end_cnt = 0;
    int tx_ones = 0;
    bit txq[$];
    logic [7:0] got[$];

    always #2.5 clk = ~clk;

    sbus_rx_deframer u_sbus_rx_deframer (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .byte_vld(byte_vld), .byte_data(byte_data), .frame_end(frame_end),
        .frame_err(frame_err), .frame_crc_ok(frame_crc_ok), .msg_kind(msg_kind),
        .msg_addr(msg_addr), .ctrl_id(ctrl_id)
    );

    always @(negedge clk) begin
        if (!rst && byte_vld) got.push_back(byte_data);
        if (!rst && frame_end) end_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    function automatic logic [15:0] fcs16(input logic [7:0] m[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (m[k]) begin
            for (int i = 0; i < 8; i++) begin
                logic fb = c[0] ^ m[k][i];
                c = {1'b0, c[15:1]};
                if (fb) c = c ^ 16'h8408;
            end
        end
        return ~c;
    endfunction

    function automatic int exp_kind(input logic [7:0] m[$]);
        if (m.size() == 1) begin
            case (m[0])
                8'h80:   return 1;
                8'h81:   return 2;
                8'h8A:   return 3;
                8'h8E:   return 4;
                default: return 5;
            endcase
        end
        if (m[0] >= 8'hA4 && m[0] <= 8'hA7) return 6;
        return 7;
    endfunction

    task automatic put_raw(input bit b);
        txq.push_back(b);
    endtask

    task automatic put_stuffed(input bit b);
        txq.push_back(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                txq.push_back(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic put_oct(input logic [7:0] o);
        for (int i = 0; i < 8; i++) put_stuffed(o[i]);
    endtask

    task automatic put_flag();
        put_raw(1'b0);
        for (int i = 0; i < 6; i++) put_raw(1'b1);
        put_raw(1'b0);
        tx_ones = 0;
    endtask

    task automatic put_mark();
        for (int i = 0; i < 8; i++) put_raw(1'b1);
    endtask

    task automatic put_body(input logic [7:0] m[$], input bit bad);
        logic [15:0] f = fcs16(m);
        if (bad) f = f ^ 16'h0100;
        foreach (m[k]) put_oct(m[k]);
        put_oct(f[7:0]);
        put_oct(f[15:8]);
    endtask

    task automatic play();
        foreach (txq[k]) begin
            @(negedge clk);
            bit_vld = 1'b1;
            bit_in  = txq[k];
            @(negedge clk);
            bit_vld = 1'b0;
            @(negedge clk);
        end
        txq.delete();
        repeat (6) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] m[$], input bit bad, input int extra);
        got.delete();
        put_flag();
        put_body(m, bad);
        for (int i = 0; i < extra; i++) put_stuffed(1'b0);
        put_flag();
        put_mark();
        play();
    endtask

    task automatic check_good(input logic [7:0] m[$]);
        chk_eq("R6/R7 kind", int'(msg_kind), exp_kind(m));
        chk_eq("R10 addr", int'(msg_addr), int'(m[0]));
        chk_eq("R5 crc_ok", int'(frame_crc_ok), 1);
        chk_eq("R8 err", int'(frame_err), 0);
        chk_eq("R4 count", got.size(), m.size());
        if (got.size() == m.size())
            foreach (m[k]) chk_eq("R4/R2 octet", int'(got[k]), int'(m[k]));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] m[$];
        int e0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk_eq("R11 byte_vld", int'(byte_vld), 0);
        chk_eq("R11 frame_end", int'(frame_end), 0);
        chk_eq("R11 report", int'({frame_err, frame_crc_ok, msg_kind, msg_addr, ctrl_id}), 0);

        // R6: named command octets
        m = {8'h80}; e0 = end_cnt; run_frame(m, 0, 0);
        chk_eq("R3 one end", end_cnt - e0, 1); chk_eq("R6 frame start", int'(msg_kind), 1); check_good(m);
        m = {8'h81}; run_frame(m, 0, 0); chk_eq("R6 frame ctrl", int'(msg_kind), 2);
        m = {8'h8A}; run_frame(m, 0, 0); chk_eq("R6 hand pilot", int'(msg_kind), 3);
        m = {8'h8E}; run_frame(m, 0, 0); chk_eq("R6 hand copilot", int'(msg_kind), 4);

        // R6/R2/R4: sweep every single-octet message
        for (int v = 0; v < 256; v++) begin
            m = {v[7:0]}; e0 = end_cnt;
            run_frame(m, 0, 0);
            chk_eq("R3 sweep end", end_cnt - e0, 1);
            check_good(m);
        end

        // R7: multi-octet first-octet sweep around the status range
        for (int a = 8'hA0; a <= 8'hAA; a++) begin
            m = {a[7:0], 8'hFF, 8'h7E, 8'h3F};
            run_frame(m, 0, 0);
            check_good(m);
            chk_eq("R7 ctrl_id", int'(ctrl_id), (a >= 8'hA4 && a <= 8'hA7) ? a - 8'hA4 : 0);
        end

        // R2: long message dense with ones
        m = {8'h11, 8'hFF, 8'hFF, 8'hFE, 8'h7F, 8'h7E, 8'h1F, 8'hF8};
        run_frame(m, 0, 0);
        check_good(m);

        // R5: corrupted check field
        m = {8'hA5, 8'h00};
        run_frame(m, 1, 0);
        chk_eq("R5 bad crc", int'(frame_crc_ok), 0);
        chk_eq("R5 bad crc no err", int'(frame_err), 0);
        chk_eq("R5 kind kept", int'(msg_kind), 6);

        // R8: non-integral length
        m = {8'h44, 8'h55};
        run_frame(m, 0, 3);
        chk_eq("R8 misaligned err", int'(frame_err), 1);
        chk_eq("R8 misaligned crc", int'(frame_crc_ok), 0);
        chk_eq("R8 misaligned kind", int'(msg_kind), 0);

        // R8: too short (one octet, no check field)
        got.delete(); e0 = end_cnt;
        put_flag(); put_oct(8'h80); put_flag(); put_mark(); play();
        chk_eq("R8 short end", end_cnt - e0, 1);
        chk_eq("R8 short err", int'(frame_err), 1);

        // R3/R10: repeated flags give no end, report holds
        m = {8'h8A}; run_frame(m, 0, 0);
        e0 = end_cnt;
        put_flag(); put_flag(); put_flag(); put_mark(); play();
        chk_eq("R3 idle flags", end_cnt - e0, 0);
        chk_eq("R10 hold kind", int'(msg_kind), 3);
        chk_eq("R10 hold addr", int'(msg_addr), 8'h8A);

        // R3: shared flag between two frames
        got.delete(); e0 = end_cnt;
        put_flag(); m = {8'h81}; put_body(m, 0);
        put_flag(); m = {8'hA7, 8'h12}; put_body(m, 0);
        put_flag(); put_mark(); play();
        chk_eq("R3 two ends", end_cnt - e0, 2);
        chk_eq("R3 second kind", int'(msg_kind), 6);
        chk_eq("R7 ctrl 4", int'(ctrl_id), 3);
        chk_eq("R4 bytes both", got.size(), 3);

        // R9: abort mid frame then hunt needs a fresh flag
        e0 = end_cnt;
        put_flag(); put_oct(8'hA1); put_oct(8'hB2); put_oct(8'hC3);
        for (int i = 0; i < 7; i++) put_raw(1'b1);
        m = {8'h55}; put_body(m, 0);
        put_flag(); put_mark(); play();
        chk_eq("R9 abort end", end_cnt - e0, 1);
        chk_eq("R9 abort err", int'(frame_err), 1);
        chk_eq("R9 abort kind", int'(msg_kind), 0);

        // R1: garbage without flags is ignored before a frame
        got.delete(); e0 = end_cnt;
        for (int i = 0; i < 40; i++) put_raw((i % 3) == 0);
        tx_ones = 0;
        put_flag(); m = {8'h80}; put_body(m, 0); put_flag(); put_mark(); play();
        chk_eq("R1 garbage end", end_cnt - e0, 1);
        chk_eq("R1 after garbage", int'(msg_kind), 1);
        chk_eq("R1 bytes", got.size(), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule